// File: doc/BRIEF.md
# Interleaved PCM Bus Slot Controller

This block is the per-device slot logic that lets one 2.048 Mb/s E1 stream share a faster PCM bus with other devices. The bus carries 32 byte channels per 125 µs frame from each of N devices, where N is 1, 2, 4 or 8. Bus slots are interleaved by channel. Slot `s` carries channel `s / N` of device `s % N`, so the bus holds channel 0 of every device, then channel 1 of every device, and so on. Each byte is sent MSB first.

The block runs on the bus bit clock and needs a single frame-sync pulse to align its bit and slot counters. In its own slots it drives the serial output and raises an output enable. The byte it sends comes from `src_byte`, which is sampled at the start of every slot. In those same slots it also collects bus bits into a captured byte and tags that byte with its channel number. It also does two more jobs:
- It selects the transmit frame sync. With interleaving on, the receive sync is used and the external one is ignored.
- It produces a transmit bit enable. This comes either from a dedicated clock input or from a divide-by-N of the bus clock.

An 8-bit control register sets the speed, the position, the enable and the transmit clock source. When interleaving is off, the block acts as a plain single-stream port.

Top module: `pcm_ilv_top`

## Requirements
- R1: The control register resets to 0. Bits 6:0 are written from `cfg_wdata` when `cfg_we` is high at a clock edge, and the new value shows on `cfg_rdata` after that edge. Bit 7 always reads 0.
- R2: The speed field is bits 5:4: 00 gives N=1, 01 gives N=2, 10 gives N=4 and 11 gives N=8. A bus frame is 32·N slots of 8 bit periods. Without a new sync the slot count wraps to 0 after slot 32·N−1, so an owner drives exactly 256 bit periods in every frame.
- R3: The position field is bits 2:0, and the enable is bit 3. The device at position p owns slots k·N+p for k = 0..31. Its first owned bit period after a sync is bit period 8·p of the frame.
- R4: `bus_oe` is high exactly in the bit periods of owned slots. In those periods `bus_dout` carries, MSB first, the `src_byte` value sampled at the edge that starts the slot. When `bus_oe` is low, `bus_dout` is 0.
- R5: If the position is greater than or equal to N, the block never raises `bus_oe` and never raises `cap_valid`.
- R6: With bit 3 clear, the block behaves as N=1 at position 0, whatever bits 5:4 and 2:0 hold.
- R7: In an owned slot, `bus_din` is sampled in each bit period, MSB first. One cycle after the edge that ends bit 7, `cap_valid` pulses for one cycle with the byte on `cap_byte` and the slot's channel on `cap_chan`.
- R8: When `rx_fsync` is high at an edge, the next cycle is bit 0 of slot 0. This applies both at start-up and in mid-frame. Before the first sync the block drives nothing and captures nothing.
- R9: `tx_fsync_out` is registered. With bit 3 set it follows `rx_fsync` one cycle later and ignores `tx_fsync_ext`. With bit 3 clear it follows `tx_fsync_ext` one cycle later.
- R10: With bit 6 set, `tx_bit_en` pulses once every N cycles, first in the cycle after a sync. With bit 6 clear, it pulses in the cycle after an edge that sees `tx_clk_in` high where it was low one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents (bit 7 is 0) |
| rx_fsync | input | 1 | Receive frame sync; aligns bus counters |
| tx_fsync_ext | input | 1 | External transmit frame sync |
| tx_clk_in | input | 1 | Dedicated transmit clock input |
| src_byte | input | 8 | Byte for the slot starting next |
| bus_din | input | 1 | Serial data from the shared bus |
| bus_dout | output | 1 | Serial data to the shared bus |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| cap_valid | output | 1 | Captured byte strobe |
| cap_byte | output | 8 | Captured byte |
| cap_chan | output | 5 | Channel of the captured byte |
| tx_fsync_out | output | 1 | Selected transmit frame sync |
| tx_bit_en | output | 1 | Transmit bit enable |

## Verification
Every result is due one cycle after the edge that causes it:
- `bus_oe` and `bus_dout` describe the bit period that begins at the edge where the counters move.
- `cap_valid` follows the edge that ends bit 7.
- `tx_fsync_out`, `tx_bit_en` and `cfg_rdata` each follow their causing edge.

The bench keeps a behavioural model that steps at each rising edge from the inputs driven at the previous falling edge. It compares the model with all outputs at the next falling edge, so each result is checked in the cycle it becomes due. Directed frame runs count the owned bit periods per frame and measure the offset of the first owned bit period from the sync.

// File: rtl/pcm_ilv_pkg.sv
package pcm_ilv_pkg;

    localparam int CTRL_W = 8;
    localparam int POS_W  = 3;

    typedef enum logic [1:0] {
        SPD_X1 = 2'b00,
        SPD_X2 = 2'b01,
        SPD_X4 = 2'b10,
        SPD_X8 = 2'b11
    } speed_e;

    // Packed so that the MSB-first member order matches register bits 6:0
    typedef struct packed {
        logic             clk_from_bus;
        speed_e           speed;
        logic             ilv_en;
        logic [POS_W-1:0] pos;
    } ctrl_t;

    // log2 of the device count actually in force
    function automatic logic [1:0] eff_log2(input ctrl_t c);
        return c.ilv_en ? 2'(c.speed) : 2'd0;
    endfunction

    // position actually in force
    function automatic logic [POS_W-1:0] eff_pos(input ctrl_t c);
        return c.ilv_en ? c.pos : '0;
    endfunction

    // true when the position lies inside the device count
    function automatic logic pos_fits(input ctrl_t c);
        logic [POS_W:0] n_dev;
        n_dev = (POS_W+1)'(1) << eff_log2(c);
        return {1'b0, eff_pos(c)} < n_dev;
    endfunction

endpackage

// File: rtl/pcm_ilv_cfg.sv
module pcm_ilv_cfg
    import pcm_ilv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rd_data
);

    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;
    logic   unused_wr_msb;

    assign unused_wr_msb = wr_data[CTRL_W-1];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl = ctrl_t'(wr_data[CTRL_W-2:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl    = st_q.ctrl;
    assign rd_data = {1'b0, st_q.ctrl};

endmodule

// File: rtl/pcm_ilv_timing.sv
module pcm_ilv_timing
    import pcm_ilv_pkg::*;
#(
    parameter  int CHANNELS  = 32,
    parameter  int BYTE_BITS = 8,
    localparam int BIT_W     = $clog2(BYTE_BITS),
    localparam int CH_W      = $clog2(CHANNELS),
    localparam int SLOT_W    = CH_W + POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       eff_lg,
    input  logic [POS_W-1:0] eff_pos,
    input  logic             pos_ok,
    input  logic             fsync,
    output logic             cur_own,
    output logic             cur_last_bit,
    output logic [CH_W-1:0]  cur_chan,
    output logic             nxt_own,
    output logic             nxt_first_bit,
    output logic             nxt_div_zero
);

    typedef struct packed {
        logic              valid;
        logic [BIT_W-1:0]  bit_idx;
        logic [SLOT_W-1:0] slot;
        logic [POS_W-1:0]  div;
    } state_t;

    state_t            st_d, st_q;
    logic [POS_W-1:0]  dev_mask;
    logic [SLOT_W-1:0] last_slot;

    always_comb begin
        dev_mask  = POS_W'((1 << eff_lg) - 1);
        last_slot = SLOT_W'((CHANNELS << eff_lg) - 1);

        st_d = st_q;
        if (fsync) begin
            st_d.valid   = 1'b1;
            st_d.bit_idx = '0;
            st_d.slot    = '0;
            st_d.div     = '0;
        end else if (st_q.valid) begin
            if (st_q.bit_idx == BIT_W'(BYTE_BITS - 1)) begin
                st_d.bit_idx = '0;
                st_d.slot    = (st_q.slot >= last_slot) ? '0 : st_q.slot + 1'b1;
            end else begin
                st_d.bit_idx = st_q.bit_idx + 1'b1;
            end
            st_d.div = (st_q.div >= dev_mask) ? '0 : st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ownership of the bit period now on the bus
    assign cur_own      = st_q.valid && pos_ok &&
                          ((st_q.slot[POS_W-1:0] & dev_mask) == eff_pos);
    assign cur_last_bit = (st_q.bit_idx == BIT_W'(BYTE_BITS - 1));
    assign cur_chan     = CH_W'(st_q.slot >> eff_lg);

    // lookahead to the bit period that starts at the coming edge
    assign nxt_own       = st_d.valid && pos_ok &&
                           ((st_d.slot[POS_W-1:0] & dev_mask) == eff_pos);
    assign nxt_first_bit = st_d.valid && (st_d.bit_idx == '0);
    assign nxt_div_zero  = st_d.valid && (st_d.div == '0);

endmodule

// File: rtl/pcm_ilv_lane.sv
module pcm_ilv_lane #(
    parameter  int CHANNELS  = 32,
    parameter  int BYTE_BITS = 8,
    localparam int CH_W      = $clog2(CHANNELS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cur_own,
    input  logic                 cur_last_bit,
    input  logic [CH_W-1:0]      cur_chan,
    input  logic                 nxt_own,
    input  logic                 nxt_first_bit,
    input  logic [BYTE_BITS-1:0] src_byte,
    input  logic                 bus_din,
    output logic                 bus_dout,
    output logic                 bus_oe,
    output logic                 cap_valid,
    output logic [BYTE_BITS-1:0] cap_byte,
    output logic [CH_W-1:0]      cap_chan
);

    typedef struct packed {
        logic [BYTE_BITS-2:0] out_sh;
        logic                 dout;
        logic                 oe;
        logic [BYTE_BITS-2:0] in_sh;
        logic                 cap_v;
        logic [BYTE_BITS-1:0] cap_b;
        logic [CH_W-1:0]      cap_c;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cap_v = 1'b0;

        // transmit: a byte is taken at every slot start, driven only when owned
        if (nxt_first_bit) begin
            st_d.out_sh = src_byte[BYTE_BITS-2:0];
            st_d.dout   = nxt_own & src_byte[BYTE_BITS-1];
        end else begin
            st_d.out_sh = {st_q.out_sh[BYTE_BITS-3:0], 1'b0};
            st_d.dout   = nxt_own & st_q.out_sh[BYTE_BITS-2];
        end
        st_d.oe = nxt_own;

        // receive: keep the latest bits, publish at the end of an owned slot
        st_d.in_sh = {st_q.in_sh[BYTE_BITS-3:0], bus_din};
        if (cur_own && cur_last_bit) begin
            st_d.cap_v = 1'b1;
            st_d.cap_b = {st_q.in_sh, bus_din};
            st_d.cap_c = cur_chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_dout  = st_q.dout;
    assign bus_oe    = st_q.oe;
    assign cap_valid = st_q.cap_v;
    assign cap_byte  = st_q.cap_b;
    assign cap_chan  = st_q.cap_c;

endmodule

// File: rtl/pcm_ilv_txsel.sv
module pcm_ilv_txsel (
    input  logic clk,
    input  logic rst_n,
    input  logic ilv_en,
    input  logic clk_from_bus,
    input  logic rx_fsync,
    input  logic tx_fsync_ext,
    input  logic tx_clk_in,
    input  logic div_zero_nxt,
    output logic tx_fsync_out,
    output logic tx_bit_en
);

    typedef struct packed {
        logic fs;
        logic tclk_prev;
        logic bit_en;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.fs        = ilv_en ? rx_fsync : tx_fsync_ext;
        st_d.tclk_prev = tx_clk_in;
        st_d.bit_en    = clk_from_bus ? div_zero_nxt
                                      : (tx_clk_in & ~st_q.tclk_prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_fsync_out = st_q.fs;
    assign tx_bit_en    = st_q.bit_en;

endmodule

// File: rtl/pcm_ilv_top.sv
module pcm_ilv_top
    import pcm_ilv_pkg::*;
#(
    parameter  int CHANNELS  = 32,
    parameter  int BYTE_BITS = 8,
    localparam int CH_W      = $clog2(CHANNELS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CTRL_W-1:0]    cfg_wdata,
    output logic [CTRL_W-1:0]    cfg_rdata,
    input  logic                 rx_fsync,
    input  logic                 tx_fsync_ext,
    input  logic                 tx_clk_in,
    input  logic [BYTE_BITS-1:0] src_byte,
    input  logic                 bus_din,
    output logic                 bus_dout,
    output logic                 bus_oe,
    output logic                 cap_valid,
    output logic [BYTE_BITS-1:0] cap_byte,
    output logic [CH_W-1:0]      cap_chan,
    output logic                 tx_fsync_out,
    output logic                 tx_bit_en
);

    ctrl_t            ctrl;
    logic [1:0]       eff_lg;
    logic [POS_W-1:0] eff_p;
    logic             pos_ok;
    logic             cur_own, cur_last_bit, nxt_own, nxt_first_bit, nxt_div_zero;
    logic [CH_W-1:0]  cur_chan;

    assign eff_lg = eff_log2(ctrl);
    assign eff_p  = eff_pos(ctrl);
    assign pos_ok = pos_fits(ctrl);

    pcm_ilv_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .ctrl    (ctrl),
        .rd_data (cfg_rdata)
    );

    pcm_ilv_timing #(
        .CHANNELS  (CHANNELS),
        .BYTE_BITS (BYTE_BITS)
    ) u_timing (
        .clk           (clk),
        .rst_n         (rst_n),
        .eff_lg        (eff_lg),
        .eff_pos       (eff_p),
        .pos_ok        (pos_ok),
        .fsync         (rx_fsync),
        .cur_own       (cur_own),
        .cur_last_bit  (cur_last_bit),
        .cur_chan      (cur_chan),
        .nxt_own       (nxt_own),
        .nxt_first_bit (nxt_first_bit),
        .nxt_div_zero  (nxt_div_zero)
    );

    pcm_ilv_lane #(
        .CHANNELS  (CHANNELS),
        .BYTE_BITS (BYTE_BITS)
    ) u_lane (
        .clk           (clk),
        .rst_n         (rst_n),
        .cur_own       (cur_own),
        .cur_last_bit  (cur_last_bit),
        .cur_chan      (cur_chan),
        .nxt_own       (nxt_own),
        .nxt_first_bit (nxt_first_bit),
        .src_byte      (src_byte),
        .bus_din       (bus_din),
        .bus_dout      (bus_dout),
        .bus_oe        (bus_oe),
        .cap_valid     (cap_valid),
        .cap_byte      (cap_byte),
        .cap_chan      (cap_chan)
    );

    pcm_ilv_txsel u_txsel (
        .clk          (clk),
        .rst_n        (rst_n),
        .ilv_en       (ctrl.ilv_en),
        .clk_from_bus (ctrl.clk_from_bus),
        .rx_fsync     (rx_fsync),
        .tx_fsync_ext (tx_fsync_ext),
        .tx_clk_in    (tx_clk_in),
        .div_zero_nxt (nxt_div_zero),
        .tx_fsync_out (tx_fsync_out),
        .tx_bit_en    (tx_bit_en)
    );

endmodule

// File: rtl/pcm_ilv_chk.sv
module pcm_ilv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       rx_fsync,
    input logic       tx_clk_in,
    input logic       bus_dout,
    input logic       bus_oe,
    input logic       cap_valid,
    input logic       tx_fsync_out,
    input logic       tx_bit_en
);

    logic synced_q;
    logic bad_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            synced_q <= 1'b0;
        end else if (rx_fsync) begin
            synced_q <= 1'b1;
        end
    end

    assign bad_pos = cfg_rdata[3] && ({1'b0, cfg_rdata[2:0]} >= (4'd1 << cfg_rdata[5:4]));

    p_msb_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7] == 1'b0);

    p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> !bus_dout);

    p_no_drive_bad_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bad_pos) |-> (!bus_oe && !cap_valid));

    p_cap_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> !cap_valid);

    p_silent_before_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !synced_q |-> (!bus_oe && !cap_valid));

    p_tx_sync_follows_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_rdata[3]) |-> (tx_fsync_out == $past(rx_fsync)));

    p_pin_clock_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_bit_en && !$past(cfg_rdata[6])) |-> $past(tx_clk_in));

endmodule

bind pcm_ilv_top pcm_ilv_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata    (cfg_rdata),
    .rx_fsync     (rx_fsync),
    .tx_clk_in    (tx_clk_in),
    .bus_dout     (bus_dout),
    .bus_oe       (bus_oe),
    .cap_valid    (cap_valid),
    .tx_fsync_out (tx_fsync_out),
    .tx_bit_en    (tx_bit_en)
);

// File: tb/pcm_ilv_top_tb.sv
`timescale 1ns/1ps
module pcm_ilv_top_tb;

    localparam int CH = 32;
    localparam int BB = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       rx_fsync = 1'b0;
    logic       tx_fsync_ext = 1'b0;
    logic       tx_clk_in = 1'b0;
    logic [7:0] src_byte = '0;
    logic       bus_din = 1'b0;
    logic       bus_dout, bus_oe, cap_valid, tx_fsync_out, tx_bit_en;
    logic [7:0] cap_byte;
    logic [4:0] cap_chan;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pcm_ilv_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_fsync(rx_fsync), .tx_fsync_ext(tx_fsync_ext),
        .tx_clk_in(tx_clk_in), .src_byte(src_byte), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .cap_valid(cap_valid),
        .cap_byte(cap_byte), .cap_chan(cap_chan), .tx_fsync_out(tx_fsync_out),
        .tx_bit_en(tx_bit_en)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // behavioural reference, stepped at each rising edge
    int m_cfg, m_bit, m_slot, m_div, m_obyte, m_acc, m_cb, m_cc;
    bit m_valid, m_dout, m_oe, m_cv, m_fs, m_tprev, m_ben;

    always @(posedge clk) begin
        int n, p, nsl, chan;
        bit en, fits, own_c, own_n;
        if (!rst_n) begin
            m_cfg = 0; m_bit = 0; m_slot = 0; m_div = 0; m_obyte = 0; m_acc = 0;
            m_cb = 0; m_cc = 0; m_valid = 0; m_dout = 0; m_oe = 0; m_cv = 0;
            m_fs = 0; m_tprev = 0; m_ben = 0;
        end else begin
            en   = m_cfg[3];
            n    = en ? (1 << ((m_cfg >> 4) & 3)) : 1;
            p    = en ? (m_cfg & 7) : 0;
            nsl  = CH * n;
            fits = (p < n);
            own_c = m_valid && fits && ((m_slot % n) == p);
            chan  = m_slot / n;
            m_acc = ((m_acc << 1) | int'(bus_din)) & 255;
            m_cv  = own_c && (m_bit == BB - 1);
            if (m_cv) begin
                m_cb = m_acc;
                m_cc = chan;
            end
            if (rx_fsync) begin
                m_valid = 1; m_bit = 0; m_slot = 0; m_div = 0;
            end else if (m_valid) begin
                m_bit = m_bit + 1;
                if (m_bit == BB) begin
                    m_bit = 0;
                    m_slot = (m_slot >= nsl - 1) ? 0 : m_slot + 1;
                end
                m_div = (m_div >= n - 1) ? 0 : m_div + 1;
            end
            own_n = m_valid && fits && ((m_slot % n) == p);
            if (m_valid && m_bit == 0) m_obyte = int'(src_byte);
            m_oe   = own_n;
            m_dout = own_n ? m_obyte[BB - 1 - m_bit] : 1'b0;
            m_fs   = en ? rx_fsync : tx_fsync_ext;
            m_ben  = m_cfg[6] ? (m_valid && m_div == 0) : (tx_clk_in && !m_tprev);
            m_tprev = tx_clk_in;
            if (cfg_we) m_cfg = int'(cfg_wdata) & 127;
        end
    end

    // compare every cycle away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(bus_oe == m_oe, "R3 R4 R5 R6 bus_oe", int'(bus_oe), int'(m_oe));
            chk(bus_dout == m_dout, "R4 bus_dout", int'(bus_dout), int'(m_dout));
            chk(cap_valid == m_cv, "R7 cap_valid", int'(cap_valid), int'(m_cv));
            if (m_cv) begin
                chk(int'(cap_byte) == m_cb, "R7 cap_byte", int'(cap_byte), m_cb);
                chk(int'(cap_chan) == m_cc, "R7 cap_chan", int'(cap_chan), m_cc);
            end
            chk(tx_fsync_out == m_fs, "R9 tx_fsync_out", int'(tx_fsync_out), int'(m_fs));
            chk(tx_bit_en == m_ben, "R10 tx_bit_en", int'(tx_bit_en), int'(m_ben));
            chk(int'(cfg_rdata) == m_cfg, "R1 cfg_rdata", int'(cfg_rdata), m_cfg);
        end
    end

    // free-running random stimulus on data and side inputs
    always @(negedge clk) begin
        bus_din      <= 1'($urandom);
        src_byte     <= 8'($urandom);
        tx_fsync_ext <= (($urandom % 7) == 0);
        tx_clk_in    <= (($urandom % 3) != 0) ? ~tx_clk_in : tx_clk_in;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_rdata == {1'b0, v[6:0]}, "R1 readback after write",
            int'(cfg_rdata), int'({1'b0, v[6:0]}));
    endtask

    // pulse a sync, then count owned bit periods over one frame of n*32 slots
    task automatic run_frame(input int n, input int exp_first, input int exp_cnt, input string tag);
        int first;
        int cnt;
        first = -1;
        cnt = 0;
        @(negedge clk);
        rx_fsync = 1'b1;
        for (int i = 0; i < CH * n * BB; i++) begin
            @(negedge clk);
            rx_fsync = 1'b0;
            if (bus_oe) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        chk(cnt == exp_cnt, {tag, " owned bit periods per frame"}, cnt, exp_cnt);
        chk(first == exp_first, {tag, " first owned bit period"}, first, exp_first);
        // second frame without a sync: wrap must repeat the pattern (R2)
        cnt = 0;
        for (int i = 0; i < CH * n * BB; i++) begin
            @(negedge clk);
            if (bus_oe) cnt++;
        end
        chk(cnt == exp_cnt, "R2 count in free-running frame", cnt, exp_cnt);
    endtask

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        chk(cfg_rdata == 8'h00, "R1 reset value", int'(cfg_rdata), 0);
        chk(bus_oe == 1'b0, "R8 no drive in reset", int'(bus_oe), 0);
        rst_n = 1'b1;

        write_cfg(8'hFF);                       // R1: bit 7 not stored
        write_cfg(8'h08);                       // enabled, N=1, position 0
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bus_oe || cap_valid) cnt++;
        end
        chk(cnt == 0, "R8 silent before first sync", cnt, 0);

        run_frame(1, 0, 256, "R2 N=1 pos0");
        write_cfg(8'h19);  run_frame(2, 8, 256, "R3 N=2 pos1");
        write_cfg(8'h2A);  run_frame(4, 16, 256, "R3 N=4 pos2");
        write_cfg(8'h3F);  run_frame(8, 56, 256, "R3 N=8 pos7");
        repeat (100) @(negedge clk);
        run_frame(8, 56, 256, "R8 mid-frame resync");
        write_cfg(8'h38);  run_frame(8, 0, 256, "R3 N=8 pos0");
        write_cfg(8'h1B);  run_frame(2, -1, 0, "R5 N=2 pos3");
        write_cfg(8'h2D);  run_frame(4, -1, 0, "R5 N=4 pos5");
        write_cfg(8'h37);  run_frame(1, 0, 256, "R6 disabled N field ignored");
        write_cfg(8'h77);  run_frame(1, 0, 256, "R6 disabled bus clock");
        write_cfg(8'h6A);  run_frame(4, 16, 256, "R10 N=4 bus-derived clock");
        write_cfg(8'h5B);  run_frame(2, -1, 0, "R10 R5 N=2 bad pos bus clock");

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule